// File: doc/BRIEF.md
# Dual-Channel Converter Update Controller

This block is the digital front end for a pair of digital-to-analog converter channels. Each channel has a control word and a data register on a small register bus. The block decides when a value written to a data register moves into the output latch that drives the converter. A field in the control word picks the event that causes this move: the data write itself, a data write while the channel is enabled, or a one-cycle pulse from either of two timers. The block also decodes the output-stage mode into pin-ownership and force-to-zero indications, and it raises a per-channel interrupt when a timed or gated transfer completes.

A grouping bit couples the two channels. While it is set, neither latch changes until both data registers have been written since the last grouped transfer. Both latches then move in the same cycle. A write counts even when it repeats the value already held. The analog converter, its reference, range scaling and settling are outside the block. The range bit only passes through to an output.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset, both output codes are 0, pin_drive is 0, force_zero is 0 and irq is 0.
- R2: The address map is: 0 = channel 0 control, 1 = channel 0 data, 2 = channel 1 control, 3 = channel 1 data, 4 = flag register. The control word fields are: bit 0 = 8-bit resolution, bit 1 = 3x range, bits 4:2 = amplifier mode, bits 6:5 = load select, bit 7 = enable, bit 8 = interrupt enable, bit 9 = group. Group is used only from channel 0. Control bits 15:10 and data bits 15:12 read back as 0.
- R3: Load select 0 latches the written value into the output code at the clock edge of the data write. It never sets the flag.
- R4: Load select 1 latches on a data write only while the enable bit is 1. A data write with enable 0 leaves the code unchanged.
- R5: Load select 2 latches the data register on a tmr_a_pulse. Load select 3 latches it on a tmr_b_pulse. A data write alone does not change the code in either mode, and the pulse for the other timer has no effect.
- R6: With the resolution bit at 1, the code takes only data bits 7:0, and its upper bits are 0. The data register still reads back all 12 bits. The range bit appears on range_3x.
- R7: Amplifier mode 000 gives pin_drive=0 and force_zero=0. Mode 001 gives pin_drive=1 and force_zero=1. Modes 010 to 111 give pin_drive=1 and force_zero=0.
- R8: A channel in amplifier mode 000 or 001 ignores all triggers. Its code holds and its flag is not set.
- R9: A completed transfer under load select 1, 2 or 3 sets the channel's flag, which is bit c of the flag register. irq[c] equals the flag ANDed with the channel's interrupt enable.
- R10: Writing a 1 to bit c of the flag register clears flag c. Writing a 0 to it has no effect. A read strobe on channel c's data address clears flag c at the next edge.
- R11: While group is 1, no code changes until both data registers have been written since the last grouped transfer, and a trigger occurs. Both active channels then latch in the same cycle and the write tracking restarts. Rewriting an unchanged value counts as a write.
- R12: The write tracking clears while group is 0. A data write made before group is cleared and set again does not count toward the next grouped transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe (clears a flag on a data address) |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| tmr_a_pulse | input | 1 | Single-cycle timer A trigger |
| tmr_b_pulse | input | 1 | Single-cycle timer B trigger |
| dac_code | output | 2x12 | Latched converter code per channel |
| pin_drive | output | 2 | Channel owns its pin (not high impedance) |
| force_zero | output | 2 | Output stage forced to 0 V |
| range_3x | output | 2 | Range select passed through |
| irq | output | 2 | Per-channel interrupt |

## Verification
Any wrong state inside the block shows at dac_code, irq or the read-back data by the clock edge that follows the offending stimulus. A stale group-tracking bit makes a grouped transfer happen on a single write, or go missing after both writes, and this is visible on the next cycle's codes. A flag that is set or cleared wrongly shows on irq, or on a read of the flag register, one edge after the trigger or the clear. A wrong trigger decode leaves a code unchanged, or changes it, at the edge of the write or pulse that should or should not have moved it.

// File: rtl/ddac_pkg.sv
// Shared types and constants for the dual converter update controller.
// Assumes exactly two channels; grouping logic relies on that.
package ddac_pkg;
    localparam int NCH    = 2;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 3'd4;

    typedef enum logic [1:0] {
        LD_WRITE    = 2'd0,
        LD_WRITE_EN = 2'd1,
        LD_TMR_A    = 2'd2,
        LD_TMR_B    = 2'd3
    } ld_sel_e;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       grp;
        logic       ie;
        logic       en;
        ld_sel_e    lsel;
        logic [2:0] amp;
        logic       rng;
        logic       res8;
    } ctl_t;
endpackage

// File: rtl/ddac_trig_sel.sv
// Trigger selector: turns the load-select field plus the raw events into one
// transfer request, and reports whether the output stage is in an active mode.
// Assumes timer pulses are single-cycle and already synchronous to clk.
module ddac_trig_sel
    import ddac_pkg::*;
(
    input  ld_sel_e    lsel,
    input  logic       en,
    input  logic [2:0] amp,
    input  logic       wr_dat,
    input  logic       tmr_a,
    input  logic       tmr_b,
    output logic       trig,
    output logic       active
);
    // Pick the event that requests a transfer for this load-select setting.
    always_comb begin
        unique case (lsel)
            LD_WRITE:    trig = wr_dat;
            LD_WRITE_EN: trig = wr_dat & en;
            LD_TMR_A:    trig = tmr_a;
            default:     trig = tmr_b;
        endcase
    end

    // Modes 000 and 001 switch the converter off.
    assign active = (amp[2:1] != 2'b00);
endmodule

// File: rtl/ddac_group.sv
// Group tracker: while grouping is on, it remembers which data registers
// have been written and releases one shared transfer once both have been written.
// With grouping off, each channel's own trigger passes straight through.
module ddac_group
    import ddac_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grp,
    input  logic [NCH-1:0] wr_dat,
    input  logic [NCH-1:0] trig,
    output logic [NCH-1:0] fire,
    output logic [NCH-1:0] trk
);
    logic ready;
    logic gfire;

    // Decide the per-channel transfer strobes.
    always_comb begin
        ready = &(trk | wr_dat);
        gfire = grp & ready & (|trig);
        fire  = grp ? {NCH{gfire}} : trig;
    end

    // Track data writes since the last grouped transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !grp || gfire) trk <= '0;
        else                         trk <= trk | wr_dat;
    end
endmodule

// File: rtl/ddac_chan.sv
// One converter channel: control word, data register, output latch and flag.
// It latches when the shared transfer strobe 'fire' is high and the output stage
// is active. A data value written in the same cycle bypasses the data register.
module ddac_chan
    import ddac_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_dat,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tmr_a,
    input  logic             tmr_b,
    input  logic             fire,
    input  logic             clr_flag,
    output ctl_t             ctl,
    output logic [DW-1:0]    dat,
    output logic [DW-1:0]    code,
    output logic             flag,
    output logic             trig,
    output logic             active
);
    localparam logic [DW-1:0] LOW8 = DW'(8'hFF);

    logic [DW-1:0] src;
    logic [DW-1:0] src_m;
    logic          xfer;

    ddac_trig_sel trig_i (
        .lsel   (ctl.lsel),
        .en     (ctl.en),
        .amp    (ctl.amp),
        .wr_dat (wr_dat),
        .tmr_a  (tmr_a),
        .tmr_b  (tmr_b),
        .trig   (trig),
        .active (active)
    );

    // Select the value to transfer and apply the 8-bit mask.
    always_comb begin
        src   = wr_dat ? wdata[DW-1:0] : dat;
        src_m = ctl.res8 ? (src & LOW8) : src;
        xfer  = fire & active;
    end

    // Control word register; reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.rsvd <= '0;
            ctl.grp  <= wdata[9];
            ctl.ie   <= wdata[8];
            ctl.en   <= wdata[7];
            ctl.lsel <= ld_sel_e'(wdata[6:5]);
            ctl.amp  <= wdata[4:2];
            ctl.rng  <= wdata[1];
            ctl.res8 <= wdata[0];
        end
    end

    // Data register holds the full written value.
    always_ff @(posedge clk) begin
        if (!rst_n)      dat <= '0;
        else if (wr_dat) dat <= wdata[DW-1:0];
    end

    // Output latch moves only on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= '0;
        else if (xfer) code <= src_m;
    end

    // Completion flag: setting wins over clearing; immediate mode never sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (xfer && ctl.lsel != LD_WRITE) flag <= 1'b1;
        else if (clr_flag)                    flag <= 1'b0;
    end
endmodule

// File: rtl/dual_dac_ctrl.sv
// Top level: register decode, two channels, the group tracker and read-back.
// Assumes one bus access per cycle and that the read data is sampled combinationally.
module dual_dac_ctrl
    import ddac_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [BUS_W-1:0]           bus_wdata,
    input  logic                       bus_rd,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic                       tmr_a_pulse,
    input  logic                       tmr_b_pulse,
    output logic [NCH-1:0][DAC_W-1:0]  dac_code,
    output logic [NCH-1:0]             pin_drive,
    output logic [NCH-1:0]             force_zero,
    output logic [NCH-1:0]             range_3x,
    output logic [NCH-1:0]             irq
);
    logic [NCH-1:0]             wr_ctl;
    logic [NCH-1:0]             wr_dat;
    logic [NCH-1:0]             clr_flag;
    logic [NCH-1:0]             trig;
    logic [NCH-1:0]             fire;
    logic [NCH-1:0]             trk;
    logic [NCH-1:0]             flags;
    logic [NCH-1:0]             active;
    ctl_t                       ctl [NCH];
    logic [NCH-1:0][BUS_W-1:0]  ctl_flat;
    logic [NCH-1:0][DAC_W-1:0]  dat;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(2 * c + 1);

        // Address decode and flag-clear sources for this channel.
        always_comb begin
            wr_ctl[c]   = bus_wr && bus_addr == CTL_A;
            wr_dat[c]   = bus_wr && bus_addr == DAT_A;
            clr_flag[c] = (bus_wr && bus_addr == FLAG_ADDR && bus_wdata[c])
                        || (bus_rd && bus_addr == DAT_A);
        end

        ddac_chan #(.DW(DAC_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl   (wr_ctl[c]),
            .wr_dat   (wr_dat[c]),
            .wdata    (bus_wdata),
            .tmr_a    (tmr_a_pulse),
            .tmr_b    (tmr_b_pulse),
            .fire     (fire[c]),
            .clr_flag (clr_flag[c]),
            .ctl      (ctl[c]),
            .dat      (dat[c]),
            .code     (dac_code[c]),
            .flag     (flags[c]),
            .trig     (trig[c]),
            .active   (active[c])
        );

        // Output-stage decode and interrupt for this channel.
        always_comb begin
            ctl_flat[c]   = ctl[c];
            pin_drive[c]  = (ctl[c].amp != 3'b000);
            force_zero[c] = (ctl[c].amp == 3'b001);
            range_3x[c]   = ctl[c].rng;
            irq[c]        = flags[c] & ctl[c].ie;
        end
    end

    ddac_group grp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .grp    (ctl[0].grp),
        .wr_dat (wr_dat),
        .trig   (trig),
        .fire   (fire),
        .trk    (trk)
    );

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(2 * c))     bus_rdata = ctl_flat[c];
            if (bus_addr == ADDR_W'(2 * c + 1)) bus_rdata = BUS_W'(dat[c]);
        end
        if (bus_addr == FLAG_ADDR) bus_rdata = BUS_W'(flags);
    end
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
// Assertion checker for dual_dac_ctrl, attached with bind below.
module dual_dac_ctrl_chk
    import ddac_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      tmr_a_pulse,
    input logic                      tmr_b_pulse,
    input logic [NCH-1:0][DAC_W-1:0] dac_code,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0][BUS_W-1:0] ctl_flat,
    input logic [NCH-1:0]            flags,
    input logic [NCH-1:0]            trk,
    input logic [NCH-1:0]            wr_dat
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R8: an inactive output stage keeps its code
        p_inactive_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ctl_flat[c][4:3]) == 2'b00) |-> $stable(dac_code[c]));

        // R6: a code loaded in 8-bit mode has clear upper bits
        p_mask8_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ctl_flat[c][0]) && !$stable(dac_code[c]))
                |-> dac_code[c][DAC_W-1:8] == '0);

        // R3: immediate mode changes the code only after a bus write
        p_lsel0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ctl_flat[c][6:5]) == 2'd0 && !$stable(dac_code[c]))
                |-> $past(bus_wr));

        // R9: a flag rises only in a non-immediate load mode
        p_flag_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[c]) |-> $past(ctl_flat[c][6:5]) != 2'd0);

        // R9: an interrupt rises only after a bus write or timer pulse
        p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(bus_wr || tmr_a_pulse || tmr_b_pulse));

        // R11: in grouped mode a code moves only if the partner was written
        p_group_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ctl_flat[0][9]) && !$stable(dac_code[c]))
                |-> $past(trk[NCH-1-c] || wr_dat[NCH-1-c]));
    end

    // R12: tracking is empty one cycle after grouping was off
    p_trk_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl_flat[0][9])) |-> trk == '0);
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DAC_W(DAC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .tmr_a_pulse (tmr_a_pulse),
    .tmr_b_pulse (tmr_b_pulse),
    .dac_code    (dac_code),
    .irq         (irq),
    .ctl_flat    (ctl_flat),
    .flags       (flags),
    .trk         (trk),
    .wr_dat      (wr_dat)
);

// File: tb/dual_dac_ctrl_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module dual_dac_ctrl_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [15:0]       bus_rdata;
    logic              tmr_a_pulse = 1'b0;
    logic              tmr_b_pulse = 1'b0;
    logic [1:0][11:0]  dac_code;
    logic [1:0]        pin_drive;
    logic [1:0]        force_zero;
    logic [1:0]        range_3x;
    logic [1:0]        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_dac_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .tmr_a_pulse (tmr_a_pulse),
        .tmr_b_pulse (tmr_b_pulse),
        .dac_code    (dac_code),
        .pin_drive   (pin_drive),
        .force_zero  (force_zero),
        .range_3x    (range_3x),
        .irq         (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit strobe, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = strobe;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input bit b);
        @(negedge clk);
        if (b) tmr_b_pulse = 1'b1; else tmr_a_pulse = 1'b1;
        @(negedge clk);
        tmr_a_pulse = 1'b0; tmr_b_pulse = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1", "code0", 32'(dac_code[0]), 0);
        check("R1", "code1", 32'(dac_code[1]), 0);
        check("R1", "pin_drive", 32'(pin_drive), 0);
        check("R1", "irq", 32'(irq), 0);
        rd(3'd0, 0, v);
        check("R1", "ctl0 readback", 32'(v), 0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(3'd2, 16'hFFFF);
        rd(3'd2, 0, v);
        check("R2", "ctl1 reserved bits", 32'(v), 32'h03FF);
        wr(3'd3, 16'hFFFF);
        rd(3'd3, 0, v);
        check("R2", "dat1 width", 32'(v), 32'h0FFF);
        check("R5", "write in timer-B mode no latch", 32'(dac_code[1]), 0);
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_immediate();
        logic [15:0] v;
        wr(3'd0, 16'h001C);
        wr(3'd1, 16'h09E7);
        check("R3", "code0 after write", 32'(dac_code[0]), 32'h9E7);
        rd(3'd4, 0, v);
        check("R3", "no flag in immediate mode", 32'(v), 0);
    endtask

    task automatic t_res8_range();
        logic [15:0] v;
        wr(3'd0, 16'h001F);
        check("R6", "range_3x", 32'(range_3x), 32'h1);
        wr(3'd1, 16'h0ABC);
        check("R6", "code0 8-bit", 32'(dac_code[0]), 32'h0BC);
        rd(3'd1, 0, v);
        check("R6", "dat0 full readback", 32'(v), 32'hABC);
    endtask

    task automatic t_amp_modes();
        wr(3'd0, 16'h0000);
        check("R7", "mode0 drive", 32'(pin_drive[0]), 0);
        check("R7", "mode0 zero", 32'(force_zero[0]), 0);
        wr(3'd0, 16'h0004);
        check("R7", "mode1 drive", 32'(pin_drive[0]), 1);
        check("R7", "mode1 zero", 32'(force_zero[0]), 1);
        wr(3'd0, 16'h0008);
        check("R7", "mode2 drive", 32'(pin_drive[0]), 1);
        check("R7", "mode2 zero", 32'(force_zero[0]), 0);
    endtask

    task automatic t_enable_gate();
        logic [15:0] v;
        wr(3'd0, 16'h003C);
        wr(3'd1, 16'h0123);
        check("R4", "no latch without enable", 32'(dac_code[0]), 32'h0BC);
        wr(3'd0, 16'h00BC);
        wr(3'd1, 16'h0456);
        check("R4", "latch with enable", 32'(dac_code[0]), 32'h456);
        rd(3'd4, 0, v);
        check("R9", "flag set in gated mode", 32'(v[0]), 1);
        check("R9", "irq masked without ie", 32'(irq[0]), 0);
        wr(3'd4, 16'h0003);
    endtask

    task automatic t_timers();
        wr(3'd0, 16'h015C);
        wr(3'd1, 16'h05A5);
        check("R5", "timer A mode waits", 32'(dac_code[0]), 32'h456);
        check("R9", "no irq before pulse", 32'(irq[0]), 0);
        pulse(0);
        check("R5", "code0 on timer A", 32'(dac_code[0]), 32'h5A5);
        check("R9", "irq0 after transfer", 32'(irq[0]), 1);
        wr(3'd2, 16'h017C);
        wr(3'd3, 16'h03C3);
        pulse(0);
        check("R5", "timer A ignored by ch1", 32'(dac_code[1]), 0);
        check("R9", "irq1 still low", 32'(irq[1]), 0);
        pulse(1);
        check("R5", "code1 on timer B", 32'(dac_code[1]), 32'h3C3);
        check("R9", "irq1 after transfer", 32'(irq[1]), 1);
    endtask

    task automatic t_flag_clear();
        logic [15:0] v;
        wr(3'd4, 16'h0000);
        check("R10", "write 0 keeps irq", 32'(irq), 32'h3);
        wr(3'd4, 16'h0001);
        check("R10", "write 1 clears bit0 only", 32'(irq), 32'h2);
        rd(3'd3, 1, v);
        check("R10", "read dat1 clears", 32'(irq), 0);
        rd(3'd4, 0, v);
        check("R10", "flag reg empty", 32'(v), 0);
    endtask

    task automatic t_inactive();
        logic [15:0] v;
        wr(3'd0, 16'h0144);
        wr(3'd1, 16'h0777);
        pulse(0);
        check("R8", "mode1 ignores timer", 32'(dac_code[0]), 32'h5A5);
        rd(3'd4, 0, v);
        check("R8", "no flag when off", 32'(v), 0);
        wr(3'd0, 16'h0140);
        pulse(0);
        check("R8", "mode0 ignores timer", 32'(dac_code[0]), 32'h5A5);
        check("R8", "irq stays low", 32'(irq), 0);
    endtask

    task automatic t_group();
        wr(3'd2, 16'h001C);
        wr(3'd0, 16'h021C);
        wr(3'd1, 16'h0111);
        check("R11", "code0 held after one write", 32'(dac_code[0]), 32'h5A5);
        check("R11", "code1 held after one write", 32'(dac_code[1]), 32'h3C3);
        wr(3'd3, 16'h0222);
        check("R11", "code0 grouped", 32'(dac_code[0]), 32'h111);
        check("R11", "code1 grouped", 32'(dac_code[1]), 32'h222);
        wr(3'd1, 16'h0111);
        check("R11", "same-value write held", 32'(dac_code[1]), 32'h222);
        wr(3'd3, 16'h0333);
        check("R11", "same-value write counted", 32'(dac_code[1]), 32'h333);
        check("R11", "code0 kept", 32'(dac_code[0]), 32'h111);
    endtask

    task automatic t_group_clear();
        wr(3'd1, 16'h0444);
        wr(3'd0, 16'h001C);
        check("R12", "ctl write no latch", 32'(dac_code[0]), 32'h111);
        wr(3'd0, 16'h021C);
        wr(3'd3, 16'h0555);
        check("R12", "old write forgotten", 32'(dac_code[1]), 32'h333);
        wr(3'd1, 16'h0666);
        check("R12", "code0 after fresh pair", 32'(dac_code[0]), 32'h666);
        check("R12", "code1 after fresh pair", 32'(dac_code[1]), 32'h555);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_immediate();
        t_res8_range();
        t_amp_modes();
        t_enable_gate();
        t_timers();
        t_flag_clear();
        t_inactive();
        t_group();
        t_group_clear();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            report();
        end
    end
endmodule